// File: doc/BRIEF.md
# Floating-Point Multiply Special-Operand Resolver

This block sits beside the mantissa multiplier of a binary64 (IEEE-754 double) multiply unit. It needs one cycle of logic and holds no state. It looks at both 64-bit operands and finds the cases the arithmetic path must not handle itself: NaN operands, infinities, zeros, and infinity times zero. For each such case it produces the final 64-bit result and raises `bypass`, so that the surrounding unit takes this result and drops whatever the multiplier produced. When both operands are finite and nonzero, `bypass` stays low and the product comes from the normal datapath.

The block also updates the sticky exception flags on the invalid-operation bit. When the invalid trap is enabled, it raises an exception instead. In that case the destination write enable is withheld and the flags pass through unchanged. The product sign, the XOR of the operand signs, is always available on its own output for the downstream datapath.

Top module: `fpm_special_resolve`

## Requirements
- R1: The sign of an infinity or zero result is the XOR of the two operand sign bits (bit 63), and `res_sign` always carries that XOR.
- R2: Infinity times zero, in either operand order, with the trap disabled, returns the default quiet NaN 64'h7FF8_0000_0000_0000, sets flag bit 4 (invalid) and asserts `res_we`.
- R3: Any invalid case with `inv_trap_en` high asserts `inv_exc`, deasserts `res_we`, and passes `flags_in` to `flags_out` unchanged. `inv_exc` is never high while the trap is disabled.
- R4: An infinity times a non-NaN, nonzero operand (finite, subnormal or infinite) returns an infinity (exponent all ones, mantissa zero).
- R5: When operand A is a signaling NaN (exponent all ones, mantissa bit 51 clear, mantissa nonzero), the result is A with bit 51 set and invalid is raised. This holds whatever operand B is.
- R6: When A is a quiet NaN (mantissa bit 51 set) and B is a signaling NaN, the result is B with bit 51 set and invalid is raised.
- R7: When A is a quiet NaN and B is not a signaling NaN, the result is A unchanged and no invalid is raised.
- R8: When only B is a NaN (A may be an infinity), the result is B, quieted and with invalid raised if B is signaling, and unchanged otherwise.
- R9: A zero operand times a finite operand returns a signed zero, with no invalid.
- R10: When both operands are finite and nonzero, `bypass`, `res_we` and `inv_exc` stay low and the flags are unchanged.
- R11: Flag bits other than bit 4 pass from `flags_in` to `flags_out` unchanged.
- R12: `res_we` is high exactly when `bypass` is high and `inv_exc` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 64 | First operand, binary64 |
| op_b | input | 64 | Second operand, binary64 |
| inv_trap_en | input | 1 | Invalid-operation trap enable |
| flags_in | input | 5 | Current sticky exception flags; bit 4 is invalid |
| res | output | 64 | Resolved result, valid when `res_we` is high |
| res_we | output | 1 | Write the resolved result to the destination |
| res_sign | output | 1 | XOR of the operand signs |
| bypass | output | 1 | Special case found; discard the datapath product |
| inv_exc | output | 1 | Invalid-operation exception (trap taken) |
| flags_out | output | 5 | Updated sticky exception flags |

## Verification
The stimulus targets NaN ordering first. With a signaling NaN in both operands, a design that ranks the operands the wrong way returns B. A quiet A paired with a signaling B catches a design that returns A without raising invalid. An infinity paired with a NaN catches a design that lets the infinity rule win over the NaN in B. Infinity times zero is applied in both operand orders and with the trap both enabled and disabled; a design that writes the destination or sets the flag while trapping is caught there. Negative zeros, subnormal operands and a finite product show whether the sign, the zero test and the `bypass` line are right.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  // Class bits of one operand, filled in by fpm_opclass.
  typedef struct packed {
    logic sign;
    logic zero;
    logic inf;
    logic nan;
    logic snan;
  } opcls_t;

  // Outcome of the infinity/zero resolution when no NaN is present.
  typedef enum logic [1:0] {
    IZ_NONE    = 2'd0,
    IZ_INVALID = 2'd1,
    IZ_INF     = 2'd2,
    IZ_ZERO    = 2'd3
  } iz_sel_t;

endpackage

// File: rtl/fpm_opclass.sv
module fpm_opclass
  import fpm_pkg::*;
#(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52
) (
  input  logic [EXP_W+MAN_W:0] op,
  output opcls_t               cls
);

  localparam int W = 1 + EXP_W + MAN_W;

  function automatic opcls_t classify(input logic [W-1:0] v);
    opcls_t c;
    logic exp_ones, exp_zero, man_zero;
    exp_ones = &v[W-2:MAN_W];
    exp_zero = ~|v[W-2:MAN_W];
    man_zero = ~|v[MAN_W-1:0];
    c.sign   = v[W-1];
    c.zero   = exp_zero & man_zero;
    c.inf    = exp_ones & man_zero;
    c.nan    = exp_ones & ~man_zero;
    c.snan   = c.nan & ~v[MAN_W-1];
    return c;
  endfunction

  always_comb cls = classify(op);

endmodule

// File: rtl/fpm_nan_pick.sv
module fpm_nan_pick
  import fpm_pkg::*;
#(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52
) (
  input  logic [EXP_W+MAN_W:0] val_a,
  input  logic [EXP_W+MAN_W:0] val_b,
  input  opcls_t               cls_a,
  input  opcls_t               cls_b,
  output logic                 nan_hit,
  output logic                 nan_inv,
  output logic [EXP_W+MAN_W:0] nan_val
);

  localparam int W = 1 + EXP_W + MAN_W;

  function automatic logic [W-1:0] quieten(input logic [W-1:0] v);
    logic [W-1:0] q;
    q = v;
    q[MAN_W-1] = 1'b1;
    return q;
  endfunction

  // Signaling A outranks signaling B, which outranks quiet A.
  always_comb begin
    nan_hit = 1'b0;
    nan_inv = 1'b0;
    nan_val = '0;
    if (cls_a.nan) begin
      nan_hit = 1'b1;
      if (cls_a.snan) begin
        nan_inv = 1'b1;
        nan_val = quieten(val_a);
      end else if (cls_b.snan) begin
        nan_inv = 1'b1;
        nan_val = quieten(val_b);
      end else begin
        nan_val = val_a;
      end
    end else if (cls_b.nan) begin
      nan_hit = 1'b1;
      nan_inv = cls_b.snan;
      nan_val = cls_b.snan ? quieten(val_b) : val_b;
    end
  end

endmodule

// File: rtl/fpm_inf_zero.sv
module fpm_inf_zero
  import fpm_pkg::*;
#(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52
) (
  input  opcls_t               cls_a,
  input  opcls_t               cls_b,
  output iz_sel_t              iz_sel,
  output logic [EXP_W+MAN_W:0] iz_val
);

  localparam int W = 1 + EXP_W + MAN_W;

  function automatic logic [W-1:0] make_inf(input logic s);
    return {s, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
  endfunction

  function automatic logic [W-1:0] make_zero(input logic s);
    return {s, {(W-1){1'b0}}};
  endfunction

  function automatic logic [W-1:0] default_qnan();
    return {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};
  endfunction

  logic prod_sign;
  assign prod_sign = cls_a.sign ^ cls_b.sign;

  // Only meaningful when neither operand is a NaN; the top gives NaN priority.
  always_comb begin
    if (cls_a.inf || cls_b.inf) begin
      iz_sel = (cls_a.zero || cls_b.zero) ? IZ_INVALID : IZ_INF;
    end else if (cls_a.zero || cls_b.zero) begin
      iz_sel = IZ_ZERO;
    end else begin
      iz_sel = IZ_NONE;
    end
  end

  always_comb begin
    unique case (iz_sel)
      IZ_INVALID: iz_val = default_qnan();
      IZ_INF:     iz_val = make_inf(prod_sign);
      IZ_ZERO:    iz_val = make_zero(prod_sign);
      default:    iz_val = '0;
    endcase
  end

endmodule

// File: rtl/fpm_special_resolve.sv
module fpm_special_resolve
  import fpm_pkg::*;
#(
  parameter int EXP_W   = 11,
  parameter int MAN_W   = 52,
  parameter int FLG_W   = 5,
  parameter int INV_POS = 4
) (
  input  logic [EXP_W+MAN_W:0] op_a,
  input  logic [EXP_W+MAN_W:0] op_b,
  input  logic                 inv_trap_en,
  input  logic [FLG_W-1:0]     flags_in,
  output logic [EXP_W+MAN_W:0] res,
  output logic                 res_we,
  output logic                 res_sign,
  output logic                 bypass,
  output logic                 inv_exc,
  output logic [FLG_W-1:0]     flags_out
);

  localparam int W = 1 + EXP_W + MAN_W;
  localparam int NOPS = 2;

  logic [W-1:0] ops  [NOPS];
  opcls_t       cls  [NOPS];

  assign ops[0] = op_a;
  assign ops[1] = op_b;

  for (genvar g = 0; g < NOPS; g++) begin : g_cls
    fpm_opclass #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .op  (ops[g]),
      .cls (cls[g])
    );
  end

  // Named internal events, visible to the bound checker.
  logic         nan_hit;
  logic         nan_inv;
  logic [W-1:0] nan_val;
  iz_sel_t      iz_sel;
  logic [W-1:0] iz_val;
  logic         invalid_evt;
  logic         special_evt;

  fpm_nan_pick #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_nan (
    .val_a   (op_a),
    .val_b   (op_b),
    .cls_a   (cls[0]),
    .cls_b   (cls[1]),
    .nan_hit (nan_hit),
    .nan_inv (nan_inv),
    .nan_val (nan_val)
  );

  fpm_inf_zero #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_iz (
    .cls_a  (cls[0]),
    .cls_b  (cls[1]),
    .iz_sel (iz_sel),
    .iz_val (iz_val)
  );

  assign invalid_evt = nan_hit ? nan_inv : (iz_sel == IZ_INVALID);
  assign special_evt = nan_hit | (iz_sel != IZ_NONE);

  assign res_sign = op_a[W-1] ^ op_b[W-1];
  assign bypass   = special_evt;
  assign inv_exc  = invalid_evt & inv_trap_en;
  assign res_we   = special_evt & ~(invalid_evt & inv_trap_en);
  assign res      = nan_hit ? nan_val : iz_val;

  always_comb begin
    flags_out = flags_in;
    if (invalid_evt && !inv_trap_en) flags_out[INV_POS] = 1'b1;
  end

endmodule

// File: rtl/fpm_chk.sv
module fpm_chk #(
  parameter int EXP_W   = 11,
  parameter int MAN_W   = 52,
  parameter int FLG_W   = 5,
  parameter int INV_POS = 4
) (
  input logic [EXP_W+MAN_W:0] op_a,
  input logic [EXP_W+MAN_W:0] op_b,
  input logic                 inv_trap_en,
  input logic [FLG_W-1:0]     flags_in,
  input logic [EXP_W+MAN_W:0] res,
  input logic                 res_we,
  input logic                 res_sign,
  input logic                 bypass,
  input logic                 inv_exc,
  input logic [FLG_W-1:0]     flags_out,
  input logic                 invalid_evt,
  input logic                 nan_hit
);

  localparam int W = 1 + EXP_W + MAN_W;
  localparam logic [FLG_W-1:0] KEEP = ~(FLG_W'(1) << INV_POS);

  logic a_special, b_special, a_zero, b_zero, any_nan, known;

  always_comb begin
    a_special = &op_a[W-2:MAN_W];
    b_special = &op_b[W-2:MAN_W];
    a_zero    = ~|op_a[W-2:0];
    b_zero    = ~|op_b[W-2:0];
    any_nan   = (a_special & |op_a[MAN_W-1:0]) | (b_special & |op_b[MAN_W-1:0]);
    known     = !$isunknown({op_a, op_b, inv_trap_en, flags_in});
  end

  always_comb begin
    if (known) begin
      // R3
      trap_blocks_write_chk: assert (!inv_exc || (!res_we && flags_out == flags_in));
      // R3
      exc_needs_trap_chk: assert (!inv_exc || inv_trap_en);
      // R2
      inv_flag_raised_chk: assert (!(invalid_evt && !inv_trap_en) || flags_out[INV_POS]);
      // R10
      finite_no_bypass_chk: assert ((a_special || b_special || a_zero || b_zero) ||
                                    (!bypass && !res_we && !inv_exc && flags_out == flags_in));
      // R11
      other_flags_chk: assert ((flags_out & KEEP) == (flags_in & KEEP));
      // R12
      we_rule_chk: assert (res_we == (bypass && !inv_exc));
      // R7
      nan_out_quiet_chk: assert (!(any_nan && res_we) || (&res[W-2:MAN_W] && res[MAN_W-1]));
      // R1
      sign_rule_chk: assert (!(bypass && !nan_hit && !invalid_evt) ||
                             (res[W-1] == res_sign && res_sign == (op_a[W-1] ^ op_b[W-1])));
    end
  end

endmodule

bind fpm_special_resolve fpm_chk #(
  .EXP_W(EXP_W), .MAN_W(MAN_W), .FLG_W(FLG_W), .INV_POS(INV_POS)
) u_chk (
  .op_a        (op_a),
  .op_b        (op_b),
  .inv_trap_en (inv_trap_en),
  .flags_in    (flags_in),
  .res         (res),
  .res_we      (res_we),
  .res_sign    (res_sign),
  .bypass      (bypass),
  .inv_exc     (inv_exc),
  .flags_out   (flags_out),
  .invalid_evt (invalid_evt),
  .nan_hit     (nan_hit)
);

// File: tb/tb_fpm_special_resolve.sv
`timescale 1ns/1ps
module tb_fpm_special_resolve;

  localparam logic [63:0] PINF = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] NINF = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] DQN  = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] SNA  = 64'h7FF0_0000_0000_0001;
  localparam logic [63:0] SNAQ = 64'h7FF8_0000_0000_0001;
  localparam logic [63:0] SNB  = 64'hFFF4_0000_0000_0000;
  localparam logic [63:0] SNBQ = 64'hFFFC_0000_0000_0000;
  localparam logic [63:0] QNA  = 64'h7FF8_0000_0000_0123;
  localparam logic [63:0] ONE  = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] NEG2 = 64'hC000_0000_0000_0000;
  localparam logic [63:0] PZ   = 64'h0000_0000_0000_0000;
  localparam logic [63:0] NZ   = 64'h8000_0000_0000_0000;
  localparam logic [63:0] DEN  = 64'h0000_0000_0000_0001;

  // {a, b, trap, exp_res, we, exc, flag_inv, bypass, tag}
  localparam int NV = 19;
  localparam logic [200:0] VEC [NV] = '{
    {PINF, PZ,   1'b0, DQN,  4'b1011, 4'd2},
    {NZ,   NINF, 1'b0, DQN,  4'b1011, 4'd2},
    {PINF, PZ,   1'b1, PZ,   4'b0101, 4'd3},
    {PINF, NEG2, 1'b0, NINF, 4'b1001, 4'd1},
    {NINF, NINF, 1'b0, PINF, 4'b1001, 4'd4},
    {ONE,  NINF, 1'b0, NINF, 4'b1001, 4'd4},
    {DEN,  PINF, 1'b0, PINF, 4'b1001, 4'd4},
    {SNA,  SNB,  1'b0, SNAQ, 4'b1011, 4'd5},
    {SNA,  ONE,  1'b1, PZ,   4'b0101, 4'd5},
    {QNA,  SNB,  1'b0, SNBQ, 4'b1011, 4'd6},
    {QNA,  DQN,  1'b0, QNA,  4'b1001, 4'd7},
    {QNA,  PINF, 1'b0, QNA,  4'b1001, 4'd7},
    {ONE,  SNB,  1'b0, SNBQ, 4'b1011, 4'd8},
    {PINF, DQN,  1'b0, DQN,  4'b1001, 4'd8},
    {PZ,   NEG2, 1'b0, NZ,   4'b1001, 4'd1},
    {NZ,   DEN,  1'b0, NZ,   4'b1001, 4'd9},
    {NZ,   NZ,   1'b0, PZ,   4'b1001, 4'd9},
    {ONE,  NEG2, 1'b0, PZ,   4'b0000, 4'd10},
    {PINF, SNB,  1'b0, SNBQ, 4'b1011, 4'd8}
  };

  logic        clk = 1'b0;
  logic [63:0] op_a = '0, op_b = '0, res;
  logic        inv_trap_en = 1'b0;
  logic [4:0]  flags_in = '0, flags_out;
  logic        res_we, res_sign, bypass, inv_exc;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  fpm_special_resolve dut (
    .op_a(op_a), .op_b(op_b), .inv_trap_en(inv_trap_en), .flags_in(flags_in),
    .res(res), .res_we(res_we), .res_sign(res_sign), .bypass(bypass),
    .inv_exc(inv_exc), .flags_out(flags_out)
  );

  function automatic string tag_name(input logic [3:0] t);
    case (t)
      4'd1:  return "R1";
      4'd2:  return "R2";
      4'd3:  return "R3";
      4'd4:  return "R4";
      4'd5:  return "R5";
      4'd6:  return "R6";
      4'd7:  return "R7";
      4'd8:  return "R8";
      4'd9:  return "R9";
      4'd10: return "R10";
      4'd11: return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic apply(input logic [63:0] a, input logic [63:0] b,
                       input logic t, input logic [4:0] f);
    @(posedge clk);
    op_a = a; op_b = b; inv_trap_en = t; flags_in = f;
    @(negedge clk);
  endtask

  // Compares {we, exc, flags, bypass} and, when a write is expected, the result.
  task automatic check(input string req, input logic [63:0] e_res, input logic e_we,
                       input logic e_exc, input logic [4:0] e_flg, input logic e_byp);
    logic [7:0] got, exp;
    got = {res_we, inv_exc, flags_out, bypass};
    exp = {e_we, e_exc, e_flg, e_byp};
    n_chk++;
    if (got !== exp || (e_we && res !== e_res)) begin
      n_fail++;
      $display("FAIL %s: a=%h b=%h ctl=%b res=%h expected ctl=%b res=%h",
               req, op_a, op_b, got, res, exp, e_res);
    end
  endtask

  initial begin
    // Watchdog
    #100000;
    if (!done) begin
      n_fail++;
      $display("FAIL R12: watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [4:0] base;
    base = 5'b01010;

    // Idle state: all-zero inputs give +0 with a write (R9).
    @(negedge clk);
    check("R9", PZ, 1'b1, 1'b0, 5'b00000, 1'b1);

    for (int i = 0; i < NV; i++) begin
      logic [200:0] v;
      logic [4:0]   ef;
      v = VEC[i];
      apply(v[200:137], v[136:73], v[72], base);
      ef = base | {v[5], 4'b0000};
      check(tag_name(v[3:0]), v[71:8], v[7], v[6], ef, v[4]);
    end

    // R11: other flag bits preserved while invalid is raised.
    apply(SNA, ONE, 1'b0, 5'b01111);
    check("R11", SNAQ, 1'b1, 1'b0, 5'b11111, 1'b1);
    // R11: flags already set stay set on a quiet operation.
    apply(QNA, ONE, 1'b0, 5'b11111);
    check("R11", QNA, 1'b1, 1'b0, 5'b11111, 1'b1);
    // R3: trap keeps flags untouched, even with the invalid bit clear.
    apply(NZ, PINF, 1'b1, 5'b00101);
    check("R3", PZ, 1'b0, 1'b1, 5'b00101, 1'b1);
    // R12: trap enabled but no invalid case still writes.
    apply(NEG2, NINF, 1'b1, 5'b00000);
    check("R12", PINF, 1'b1, 1'b0, 5'b00000, 1'b1);
    // R10: finite product with trap enabled leaves everything idle.
    apply(DEN, NEG2, 1'b1, 5'b10000);
    check("R10", PZ, 1'b0, 1'b0, 5'b10000, 1'b0);

    // R1: sign output on a finite product.
    n_chk++;
    if (res_sign !== 1'b1) begin
      n_fail++;
      $display("FAIL R1: res_sign=%b expected=1", res_sign);
    end
    apply(NEG2, NZ, 1'b0, 5'b00000);
    n_chk++;
    if (res_sign !== 1'b0 || res !== PZ) begin
      n_fail++;
      $display("FAIL R1: res_sign=%b res=%h expected 0 %h", res_sign, res, PZ);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule